// File: doc/BRIEF.md
# Prescaled Pin Glitch Filter

This block cleans up one asynchronous input pin before the rest of the chip samples it or looks at it for interrupt events. The raw pin is first brought into the core clock domain through two flip-flops. The synchronized level is then compared with the current filtered level. A different level is adopted only once it has held without a break for a programmed number of core clock cycles.

The hold time comes from two 4-bit configuration fields: a count and a prescale shift. The window is the count multiplied by two raised to the shift, in core cycles. A small count field therefore covers a very wide range, from a single cycle up to 15 × 2^15 cycles. With a 2.5 ns core clock, 400 cycles make one microsecond, and the largest window is about 1228 µs. A configuration word that is all zero has both fields at 0, which turns the filter off. A typical setting is a count of 9 with a shift of 4.

Top module: `pin_deglitch`

## Requirements
- R1: While reset is asserted the filtered output is low and the prescaler and window counter are cleared, whatever level the pin has.
- R2: The pin reaches the filter through a two-flop synchronizer, so the output never changes earlier than the third rising clock edge after the pin changes.
- R3: With a count of 0 the filter is bypassed, and a pin change appears at the output on the third rising edge after it.
- R4: With a nonzero count, a new pin level is adopted on rising edge N+2 after the pin change, where N = count × 2^shift.
- R5: A new level that lasts only N-1 synchronized cycles before the pin returns is discarded, and the output keeps its level.
- R6: If the synchronized pin returns to the output level at any point in the window, the prescaler and the counter restart. A later change then needs a full N cycles again.
- R7: Rising and falling changes are filtered with the same window and the same latency.
- R8: The shift field accepts every value from 0 to 15. The prescaler is wide enough for the largest window, 15 × 2^15 = 491520 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_raw | input | 1 | Asynchronous pin level |
| win_count | input | 4 | Window count; 0 bypasses the filter |
| win_shift | input | 4 | Prescale shift; the window is win_count × 2^win_shift |
| pin_clean | output | 1 | Filtered level |

## Verification
Each result is due at a fixed edge, counted from the falling edge at which the bench drives the pin. An accepted change is due on rising edge N+2, where N is 1 in bypass and count × 2^shift otherwise. A rejected pulse must still be absent N+4 edges after the pin returns. The bench drives the pin on falling edges, samples the output on the falling edge after each rising edge, and counts the rising edges until the output flips. The check then compares that count with N+2, so an early change fails it just as a late one does. The sweep covers every count at shifts 0 to 4, in both directions, together with short pulses and interrupted windows, plus one very long window at shift 12.

// File: rtl/pin_deglitch.sv
module pin_deglitch #(
  parameter int CNT_W = 4,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_raw,
  input  logic [CNT_W-1:0] win_count,
  input  logic [SEL_W-1:0] win_shift,
  output logic             pin_clean
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic             sync1, sync2;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PRE_W-1:0] pre_lim;
  logic             pre_done, cnt_last, bypass;

  assign pre_lim  = ~({PRE_W{1'b1}} << win_shift);
  assign pre_done = (pre_q >= pre_lim);
  assign cnt_last = ({1'b0, cnt_q} + 1'b1) >= {1'b0, win_count};
  assign bypass   = (win_count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1     <= 1'b0;
      sync2     <= 1'b0;
      pre_q     <= '0;
      cnt_q     <= '0;
      pin_clean <= 1'b0;
    end else begin
      sync1 <= pin_raw;
      sync2 <= sync1;
      if (bypass) begin
        pin_clean <= sync2;
        pre_q     <= '0;
        cnt_q     <= '0;
      end else if (sync2 == pin_clean) begin
        pre_q <= '0;
        cnt_q <= '0;
      end else if (pre_done) begin
        pre_q <= '0;
        if (cnt_last) begin
          pin_clean <= sync2;
          cnt_q     <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assert_reset_low_R1: assert property (@(posedge clk)
    !rst_n |=> (!pin_clean && pre_q == '0 && cnt_q == '0));

  assert_change_traces_pin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_clean != $past(pin_clean)) |-> (pin_clean == $past(pin_raw, 3)));

  assert_change_needs_mismatch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_clean != $past(pin_clean)) |-> ($past(sync2) != $past(pin_clean)));

  assert_clear_on_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_clean != $past(pin_clean)) |-> (pre_q == '0 && cnt_q == '0));
endmodule

// File: tb/test_pin_deglitch.sv
module test_pin_deglitch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_raw = 1'b0;
  logic [3:0] win_count = 4'd0;
  logic [3:0] win_shift = 4'd0;
  logic       pin_clean;
  int         n_cmp = 0;
  int         n_bad = 0;

  always #4 clk = ~clk;

  pin_deglitch i_pin_deglitch (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw),
    .win_count(win_count), .win_shift(win_shift), .pin_clean(pin_clean)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (count %0d shift %0d)",
               req, act, exp, win_count, win_shift);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic measure(input logic lvl, input int n, input string req);
    int k;
    k = 0;
    pin_raw = lvl;
    while (pin_clean != lvl && k < n + 10) begin
      step();
      k++;
    end
    check(k == n + 2, req, k, n + 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int n;
    @(negedge clk);
    pin_raw = 1'b1;
    repeat (5) step();
    check(pin_clean == 1'b0, "R1 reset holds output low", pin_clean, 0);
    pin_raw = 1'b0;
    step();
    rst_n = 1'b1;
    step();
    check(pin_clean == 1'b0, "R1 output low after reset", pin_clean, 0);

    for (int s = 0; s <= 4; s++) begin
      for (int c = 0; c <= 15; c++) begin
        win_shift = 4'(s);
        win_count = 4'(c);
        n = (c == 0) ? 1 : (c << s);
        step();
        if (n >= 2) begin
          pin_raw = 1'b1;
          repeat (n - 1) step();
          pin_raw = 1'b0;
          repeat (n + 4) step();
          check(pin_clean == 1'b0, "R5 short pulse discarded", pin_clean, 0);
          pin_raw = 1'b1;
          repeat (n - 1) step();
          pin_raw = 1'b0;
          step();
          measure(1'b1, n, "R6 restart then full window rise");
        end else begin
          measure(1'b1, n, (c == 0) ? "R3 bypass rise" : "R4 window rise");
        end
        measure(1'b0, n, (c == 0) ? "R3 bypass fall R7" : "R7 window fall");
        if (c == 9 && s == 4)
          check(pin_clean == 1'b0, "R4 typical setting settles low", pin_clean, 0);
      end
    end

    win_count = 4'd15;
    win_shift = 4'd12;
    step();
    measure(1'b1, 15 << 12, "R8 long window rise");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule